// File: doc/BRIEF.md
# Bidirectional Zero-Blanking Display Controller

This block feeds an eight-position decimal readout that has four integer positions, a fixed decimal point and four fractional positions. Each cycle it takes eight 4-bit digit codes and works out which positions carry zeros that add nothing to the value. These are the run of zeros above the first significant integer digit and the run of zeros below the last significant fractional digit. Those positions are blanked so that the readout follows normal written form. The integer units position always stays visible, so a value of zero still reads as "0".

A brightness control is laid over the blanking. A free-running counter is compared with an 8-bit intensity setting. In every cycle where the counter is not below the setting, all positions go dark, so the share of lit time follows the setting. Each position also gets a seven-segment pattern, and that pattern is forced to all-off whenever the position is blanked. All outputs are registered. Display multiplexing and drive circuitry sit outside this block.

Top module: `zsupp_display_ctrl`

## Requirements
- R1: Nibble k of `digits_i` (bits 4k+3..4k) holds position k. Positions 7..4 are the integer half, with 7 the most significant. Positions 3..0 are the fractional half, with 3 next to the point and 0 the least significant. Bit k of `blank_o` and bits 7k+6..7k of `seg_o` belong to position k.
- R2: With suppression enabled, the integer positions are zero-blanked from position 7 downward. Blanking continues while the digit is zero and stops at the first nonzero digit.
- R3: Position 4, the integer units, is never zero-blanked, even when it and all higher positions are zero.
- R4: With suppression enabled, the fractional positions are zero-blanked from position 0 upward. Blanking continues while the digit is zero and stops at the first nonzero digit.
- R5: Digit codes 10 to 15 count as nonzero. They stop a blanking run and are never zero-blanked.
- R6: While `supp_en_i` is low, no position is zero-blanked.
- R7: A modulation counter is cleared by reset and advances by one each cycle, wrapping at 256. If the counter value at the capturing edge is not below `level_i`, every position is blanked. A level of 0 keeps the display dark, and a level of L lights it in L of every 256 cycles.
- R8: `seg_o` uses a=bit0 through g=bit6, active high. Codes 0..F map to 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71 (hex). A blanked position outputs 00.
- R9: Outputs show the inputs captured at the previous rising edge. While `rst` is high, `blank_o` is all ones and `seg_o` is all zeros.
- R10: The input 0060.0300 (digits_i = 32'h00600300, suppression on, lit cycle) blanks positions 7, 6, 1 and 0 (blank_o = 8'hC3), so the readout shows 60.03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| digits_i | input | 32 | Eight 4-bit digit codes, position k in nibble k |
| supp_en_i | input | 1 | Enables zero blanking |
| level_i | input | 8 | Intensity setting compared with the modulation counter |
| blank_o | output | 8 | Per-position blank flag (zero blanking OR dark phase) |
| seg_o | output | 56 | Seven-segment pattern per position, all off when blanked |

## Verification
Some properties are checked on every cycle. These are: the modulation counter steps by one, a zero intensity darkens every position, a blanked position never drives a segment, and with suppression off nothing is zero-blanked. The chain itself has a cycle check that a zero-blanked position holds a zero code. Other behaviour can only be shown by the bench's scenarios. This includes where each blanking run stops, the protection of the units position, the 60.03 example, the hex letter patterns, and the exact lit fraction over a full counter period. The bench compares these against a reference model on table vectors and on random digit strings with many zeros.

// File: rtl/zsupp_pkg.sv
package zsupp_pkg;
  localparam int NIB_W = 4;
  localparam int SEG_W = 7;
  typedef logic [SEG_W-1:0] seg_t;
endpackage

// File: rtl/zsupp_seg_decode.sv
module zsupp_seg_decode
  import zsupp_pkg::*;
(
  input  logic [NIB_W-1:0] nib_i,
  output seg_t             seg_o
);
  always_comb begin
    unique case (nib_i)
      4'h0: seg_o = 7'h3F;
      4'h1: seg_o = 7'h06;
      4'h2: seg_o = 7'h5B;
      4'h3: seg_o = 7'h4F;
      4'h4: seg_o = 7'h66;
      4'h5: seg_o = 7'h6D;
      4'h6: seg_o = 7'h7D;
      4'h7: seg_o = 7'h07;
      4'h8: seg_o = 7'h7F;
      4'h9: seg_o = 7'h6F;
      4'hA: seg_o = 7'h77;
      4'hB: seg_o = 7'h7C;
      4'hC: seg_o = 7'h39;
      4'hD: seg_o = 7'h5E;
      4'hE: seg_o = 7'h79;
      default: seg_o = 7'h71;
    endcase
  end
endmodule

// File: rtl/zsupp_blank_chain.sv
module zsupp_blank_chain
  import zsupp_pkg::*;
#(
  parameter int INT_DIGITS  = 4,
  parameter int FRAC_DIGITS = 4
) (
  input  logic                                        en_i,
  input  logic [(INT_DIGITS+FRAC_DIGITS)*NIB_W-1:0]   digits_i,
  output logic [INT_DIGITS+FRAC_DIGITS-1:0]           zblank_o
);
  localparam int N     = INT_DIGITS + FRAC_DIGITS;
  localparam int UNITS = FRAC_DIGITS;

  logic [N-1:0] is_zero;

  for (genvar k = 0; k < N; k++) begin : g_zero
    assign is_zero[k] = (digits_i[k*NIB_W +: NIB_W] == '0);
  end

  // Integer run walks down from the top, fraction run walks up from the bottom.
  always_comb begin
    logic run_int;
    logic run_frac;
    zblank_o = '0;
    run_int  = en_i;
    for (int i = N-1; i > UNITS; i--) begin
      run_int     = run_int & is_zero[i];
      zblank_o[i] = run_int;
    end
    run_frac = en_i;
    for (int j = 0; j < FRAC_DIGITS; j++) begin
      run_frac    = run_frac & is_zero[j];
      zblank_o[j] = run_frac;
    end
  end

  always_comb begin
    // R6
    if (!en_i) begin
      nosupp_chk: assert (zblank_o == '0);
    end
    // R2 R4: only zero codes are ever zero-blanked
    for (int k = 0; k < N; k++) begin
      if (zblank_o[k]) begin
        zcode_chk: assert (digits_i[k*NIB_W +: NIB_W] == '0);
      end
    end
  end
endmodule

// File: rtl/zsupp_pwm_gate.sv
module zsupp_pwm_gate #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level_i,
  output logic         lit_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign lit_o = (cnt_q < level_i);

  // R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cnt_q == W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/zsupp_display_ctrl.sv
module zsupp_display_ctrl
  import zsupp_pkg::*;
#(
  parameter int INT_DIGITS  = 4,
  parameter int FRAC_DIGITS = 4,
  parameter int PWM_W       = 8
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic [(INT_DIGITS+FRAC_DIGITS)*NIB_W-1:0]   digits_i,
  input  logic                                        supp_en_i,
  input  logic [PWM_W-1:0]                            level_i,
  output logic [INT_DIGITS+FRAC_DIGITS-1:0]           blank_o,
  output logic [(INT_DIGITS+FRAC_DIGITS)*SEG_W-1:0]   seg_o
);
  localparam int N = INT_DIGITS + FRAC_DIGITS;

  logic [N-1:0] zblank;
  logic         lit;
  seg_t         pat [N];

  zsupp_blank_chain #(
    .INT_DIGITS (INT_DIGITS),
    .FRAC_DIGITS(FRAC_DIGITS)
  ) chain_i (
    .en_i    (supp_en_i),
    .digits_i(digits_i),
    .zblank_o(zblank)
  );

  zsupp_pwm_gate #(.W(PWM_W)) pwm_i (
    .clk    (clk),
    .rst    (rst),
    .level_i(level_i),
    .lit_o  (lit)
  );

  for (genvar k = 0; k < N; k++) begin : g_dec
    zsupp_seg_decode dec_i (
      .nib_i(digits_i[k*NIB_W +: NIB_W]),
      .seg_o(pat[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blank_o <= '1;
      seg_o   <= '0;
    end else begin
      for (int k = 0; k < N; k++) begin
        blank_o[k]                <= zblank[k] | ~lit;
        seg_o[k*SEG_W +: SEG_W]   <= (zblank[k] | ~lit) ? '0 : pat[k];
      end
    end
  end

  // R7
  dark_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(level_i) == '0) |-> (blank_o == '1));

  for (genvar k = 0; k < N; k++) begin : g_chk
    // R8
    segoff_chk: assert property (@(posedge clk) disable iff (rst)
      blank_o[k] |-> (seg_o[k*SEG_W +: SEG_W] == '0));
  end
endmodule

// File: tb/zsupp_display_ctrl_tb_top.sv
`timescale 1ns/1ps
module zsupp_display_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] digits = '0;
  logic        en = 1'b0;
  logic [7:0]  lvl = '0;
  logic [7:0]  blank;
  logic [55:0] seg;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  zsupp_display_ctrl dut_i (
    .clk(clk), .rst(rst), .digits_i(digits), .supp_en_i(en),
    .level_i(lvl), .blank_o(blank), .seg_o(seg)
  );

  // Model of the R7 counter: value seen at the most recent edge.
  logic [7:0] bcnt = '0;
  logic [7:0] used_cnt = '0;
  always @(posedge clk) begin
    used_cnt <= bcnt;
    bcnt     <= rst ? 8'd0 : bcnt + 8'd1;
  end

  localparam logic [31:0] VEC_D [8] = '{
    32'h0060_0300, 32'h0000_0000, 32'h1234_5678, 32'h0000_0001,
    32'h0001_1000, 32'h0A00_00B0, 32'h9000_0009, 32'h0F00_0000};
  localparam logic [7:0] VEC_B [8] = '{
    8'hC3, 8'hEF, 8'h00, 8'hE0, 8'hE7, 8'h81, 8'h00, 8'h8F};

  function automatic logic [6:0] ref_seg(input logic [3:0] c);
    case (c)
      4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
      4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
      4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
      4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
    endcase
  endfunction

  function automatic logic [7:0] ref_zb(input logic [31:0] d, input logic e);
    logic [7:0] r = '0;
    if (!e) return r;
    for (int i = 7; i >= 5; i--) begin
      if (d[i*4 +: 4] != 0) break;
      r[i] = 1'b1;
    end
    for (int j = 0; j <= 3; j++) begin
      if (d[j*4 +: 4] != 0) break;
      r[j] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [55:0] ref_segs(input logic [31:0] d, input logic [7:0] b);
    logic [55:0] s = '0;
    for (int k = 0; k < 8; k++)
      s[k*7 +: 7] = b[k] ? 7'h00 : ref_seg(d[k*4 +: 4]);
    return s;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, sample at the next falling edge.
  task automatic apply(input logic [31:0] d, input logic e, input logic [7:0] l,
                       input logic [7:0] zb_exp, input string req);
    logic [7:0] b_exp;
    digits = d; en = e; lvl = l;
    @(negedge clk);
    b_exp = zb_exp | ((used_cnt < l) ? 8'h00 : 8'hFF);
    check({req, " blank"}, 64'(blank), 64'(b_exp));
    check({req, " seg"},   64'(seg),   64'(ref_segs(d, b_exp)));
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9 reset state
    check("R9 reset blank", 64'(blank), 64'hFF);
    check("R9 reset seg", 64'(seg), 64'h0);
    rst = 1'b0;

    // Table walk: R1 R2 R3 R4 R5 R10 with suppression on, R6 with it off
    for (int v = 0; v < 8; v++) begin
      apply(VEC_D[v], 1'b1, 8'hFF, VEC_B[v], "R2 R3 R4 R5 R10 table");
      check("R2 R4 model agrees with table", 64'(ref_zb(VEC_D[v], 1'b1)), 64'(VEC_B[v]));
    end
    for (int v = 0; v < 8; v++)
      apply(VEC_D[v], 1'b0, 8'hFF, 8'h00, "R6 suppression off");

    // R10 example, R3 all zeros shows units
    apply(32'h0060_0300, 1'b1, 8'hFF, 8'hC3, "R10 0060.0300");
    apply(32'h0000_0000, 1'b1, 8'hFF, 8'hEF, "R3 all zero");
    // R8 R5 hex letters
    apply(32'h89AB_CDEF, 1'b1, 8'hFF, 8'h00, "R8 R5 hex letters");
    apply(32'h0000_0000, 1'b0, 8'hFF, 8'h00, "R8 R6 zeros shown");

    // R7 level 0 stays dark
    for (int c = 0; c < 20; c++)
      apply(32'h1234_5678, 1'b1, 8'h00, 8'h00, "R7 level zero");

    // R7 lit fraction over a full period
    begin
      int lit_n = 0;
      digits = 32'h1234_5678; en = 1'b1; lvl = 8'd128;
      @(negedge clk);
      for (int c = 0; c < 256; c++) begin
        @(negedge clk);
        if (blank == 8'h00) lit_n++;
      end
      check("R7 lit count level 128", 64'(lit_n), 64'd128);
      lit_n = 0;
      lvl = 8'd1;
      @(negedge clk);
      for (int c = 0; c < 256; c++) begin
        @(negedge clk);
        if (blank == 8'h00) lit_n++;
      end
      check("R7 lit count level 1", 64'(lit_n), 64'd1);
    end

    // Random digit strings biased toward zeros, R2 R4 R6 R7 against the model
    for (int r = 0; r < 400; r++) begin
      logic [31:0] d;
      logic        e;
      logic [7:0]  l;
      for (int k = 0; k < 8; k++)
        d[k*4 +: 4] = ($urandom % 3 == 0) ? 4'($urandom % 16) : 4'h0;
      e = ($urandom % 4) != 0;
      l = (r % 5 == 0) ? 8'($urandom) : 8'hFF;
      apply(d, e, l, ref_zb(d, e), "R2 R4 R6 R7 random");
    end

    // R9 mid-run reset
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9 mid reset blank", 64'(blank), 64'hFF);
    check("R9 mid reset seg", 64'(seg), 64'h0);
    rst = 1'b0;
    apply(32'h0000_0001, 1'b1, 8'hFF, 8'hE0, "R9 R3 after reset");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule